// File: doc/BRIEF.md
# Prescaled Compare-Match Up-Counter

This block is a periodic timer built from a 24-bit up-counter and an 8-bit clock divider. While running, the counter climbs from 0 to a programmed compare value. It emits a one-cycle match pulse when it lands on that value, and it returns to 0 on its next step. Instead of the divided clock, the counter can advance on a chosen edge of an external event pin. That pin passes through a two-flop synchronizer, and a four-sample glitch filter can be switched in after it.

Software programs the block through a small write channel with a valid/ready handshake. A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` drops only while a self-timed clear sequence runs. The writer must then hold its address and data steady until `wr_ready` comes back. A debug-halt input can freeze counting unless a bypass bit is set. The live count and an activity flag are always visible at the ports.

Top module: `match_timer`

## Requirements
- R1: After reset, `count` is 0, `match_pulse` is 0, `active` is 0, `wr_ready` is 1, the prescale value is 0 and the timer is disabled.
- R2: Register address 1 bits [7:0] hold the divide value P. While enabled in timer mode, `count` rises by exactly 1 every P+1 clocks. The first step lands P+1 clocks after the edge that accepted the enabling write.
- R3: Register address 2 bits [23:0] hold the compare value C. When `count` becomes C, `match_pulse` is high for exactly that one cycle. The next step takes `count` to 0, so the period is C+1 steps.
- R4: A compare value of 0 or 1 behaves exactly as 2.
- R5: An accepted write to address 2 sets `count` and the divider to 0 on that same edge, whether the timer is enabled or not.
- R6: Address 0 is the control register. A control write with bit 1 set clears `count` and the divider and forces the enable bit (bit 0) to 0. `wr_ready` is then low for exactly 3 cycles, and no write is accepted during that time.
- R7: While `dbg_halt` is high and control bit 2 (bypass) is 0, `count` and the divider hold. With bit 2 set, counting carries on regardless of `dbg_halt`.
- R8: With control bit 3 set (event mode), the divider is ignored. `count` rises by 1 per edge of `evt_pin` of the kind picked by bit 4 (0 = falling, 1 = rising). The other edge has no effect. With the filter off, the count changes on the 4th clock edge after the pin changes.
- R9: With control bit 5 set, the pin must hold a new level for 4 consecutive samples before the edge counts. A pulse of 2 clocks is ignored. A held change shows in `count` on the 8th clock edge after the pin moves.
- R10: `active` is high exactly when the enable bit is set and counting is not frozen by `dbg_halt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be accepted; low during a clear sequence |
| wr_addr | input | 2 | Register select: 0 control, 1 prescale, 2 compare |
| wr_data | input | 32 | Write data |
| dbg_halt | input | 1 | Debug acknowledge; freezes counting unless bypassed |
| evt_pin | input | 1 | External event pin (asynchronous) |
| count | output | 24 | Live counter value |
| match_pulse | output | 1 | One-cycle pulse while count equals the compare value |
| active | output | 1 | Counter is enabled and not frozen |

## Verification
Every check samples on the falling edge, half a cycle after the rising edge that updated the state. A register write takes effect on its acceptance edge, so its results show at the falling edge that follows. A timer-mode step lands P+1 edges after that. An event edge shows 4 edges after the pin moves, or 8 edges with the filter on. The bench waits exactly those counts and also samples one edge earlier to confirm nothing changed too soon. The ready-low window of a clear is counted edge by edge.

// File: rtl/match_timer_pkg.sv
`timescale 1ns/1ps
package match_timer_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL     = 2'd0,
    REG_PRESCALE = 2'd1,
    REG_COMPARE  = 2'd2,
    REG_SPARE    = 2'd3
  } reg_sel_e;

  // control register bit positions
  localparam int B_RUN    = 0;
  localparam int B_CLEAR  = 1;
  localparam int B_BYPASS = 2;
  localparam int B_EVT    = 3;
  localparam int B_RISE   = 4;
  localparam int B_FILT   = 5;

  typedef struct packed {
    logic filt;
    logic rise;
    logic evt;
    logic bypass;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/mt_regs.sv
`timescale 1ns/1ps
module mt_regs
  import match_timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 24,
  parameter int PRE_W   = 8,
  parameter int CLR_CYC = 3,
  parameter int MIN_CMP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic [PRE_W-1:0]  prescale,
  output logic [CNT_W-1:0]  cmp_eff,
  output logic              restart,
  output logic              clr_req,
  output logic              clearing
);
  localparam int BUSY_W = $clog2(CLR_CYC + 1);

  logic [BUSY_W-1:0] busy_q;
  logic [CNT_W-1:0]  cmp_q;
  logic              accept;
  reg_sel_e          sel;
  logic              unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CNT_W];
  assign sel       = reg_sel_e'(wr_addr);
  assign wr_ready  = (busy_q == '0);
  assign accept    = wr_valid && wr_ready;
  assign clr_req   = accept && (sel == REG_CTRL) && wr_data[B_CLEAR];
  assign restart   = accept && (sel == REG_COMPARE);
  assign clearing  = clr_req || (busy_q != '0);
  assign cmp_eff   = (cmp_q < CNT_W'(MIN_CMP)) ? CNT_W'(MIN_CMP) : cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= '0;
      ctrl     <= '0;
      prescale <= '0;
      cmp_q    <= '0;
    end else begin
      if (busy_q != '0) busy_q <= busy_q - 1'b1;
      if (accept) begin
        case (sel)
          REG_CTRL: begin
            ctrl.run    <= wr_data[B_RUN] & ~wr_data[B_CLEAR];
            ctrl.bypass <= wr_data[B_BYPASS];
            ctrl.evt    <= wr_data[B_EVT];
            ctrl.rise   <= wr_data[B_RISE];
            ctrl.filt   <= wr_data[B_FILT];
            if (wr_data[B_CLEAR]) busy_q <= BUSY_W'(CLR_CYC);
          end
          REG_PRESCALE: prescale <= wr_data[PRE_W-1:0];
          REG_COMPARE:  cmp_q    <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mt_evt_cond.sv
`timescale 1ns/1ps
module mt_evt_cond #(
  parameter int FILT_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic filt_en,
  input  logic rise_sel,
  output logic edge_o
);
  logic s1, s2, lvl, lvl_d;
  logic all_hi, all_lo;

  generate
    if (FILT_N > 1) begin : g_hist
      logic [FILT_N-1:0] hist;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[FILT_N-2:0], s2};
      end
      assign all_hi = &hist;
      assign all_lo = ~|hist;
    end else begin : g_nohist
      assign all_hi = s2;
      assign all_lo = ~s2;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      lvl   <= 1'b0;
      lvl_d <= 1'b0;
    end else begin
      s1    <= pin;
      s2    <= s1;
      lvl_d <= lvl;
      if (!filt_en)    lvl <= s2;
      else if (all_hi) lvl <= 1'b1;
      else if (all_lo) lvl <= 1'b0;
    end
  end

  assign edge_o = rise_sel ? (lvl & ~lvl_d) : (~lvl & lvl_d);
endmodule

// File: rtl/mt_prescaler.sv
`timescale 1ns/1ps
module mt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  assign tick = advance && (pre_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (clear)   pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else if (advance) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/mt_counter.sv
`timescale 1ns/1ps
module mt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  logic [CNT_W-1:0] nxt;
  assign nxt = count + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      match <= 1'b0;
    end else if (clear) begin
      count <= '0;
      match <= 1'b0;
    end else begin
      match <= step && (count != cmp) && (nxt == cmp);
      if (step) count <= (count == cmp) ? '0 : nxt;
    end
  end
endmodule

// File: rtl/match_timer.sv
`timescale 1ns/1ps
module match_timer
  import match_timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 24,
  parameter int PRE_W   = 8,
  parameter int CLR_CYC = 3,
  parameter int FILT_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbg_halt,
  input  logic              evt_pin,
  output logic [CNT_W-1:0]  count,
  output logic              match_pulse,
  output logic              active
);
  ctrl_t            ctrl;
  logic [PRE_W-1:0] prescale;
  logic [CNT_W-1:0] cmp_eff;
  logic             restart, clr_req, clearing;
  logic             freeze, running, tick, evt_edge, step, clear_all;
  logic             bypass_w;

  mt_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W), .CLR_CYC(CLR_CYC), .MIN_CMP(2)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctrl(ctrl), .prescale(prescale),
    .cmp_eff(cmp_eff), .restart(restart), .clr_req(clr_req), .clearing(clearing)
  );

  assign bypass_w  = ctrl.bypass;
  assign freeze    = dbg_halt & ~ctrl.bypass;
  assign running   = ctrl.run & ~freeze & ~clearing;
  assign active    = ctrl.run & ~freeze;
  assign clear_all = clearing | restart;

  mt_evt_cond #(.FILT_N(FILT_N)) u_evt (
    .clk(clk), .rst_n(rst_n), .pin(evt_pin), .filt_en(ctrl.filt),
    .rise_sel(ctrl.rise), .edge_o(evt_edge)
  );

  mt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(clear_all),
    .advance(running & ~ctrl.evt), .div(prescale), .tick(tick)
  );

  assign step = ctrl.evt ? (running & evt_edge) : tick;

  mt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(clear_all), .step(step),
    .cmp(cmp_eff), .count(count), .match(match_pulse)
  );
endmodule

// File: rtl/match_timer_chk.sv
`timescale 1ns/1ps
module match_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             dbg_halt,
  input logic             bypass,
  input logic             clr_req,
  input logic [CNT_W-1:0] cmp_eff,
  input logic [CNT_W-1:0] count,
  input logic             match_pulse,
  input logic             active
);
  assert_step_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> (count == $past(count) + CNT_W'(1)) || (count == '0));

  assert_match_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);

  assert_match_at_cmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> count == cmp_eff);

  assert_clear_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (!active && !wr_ready && count == '0));

  assert_clear_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> count == '0);

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !bypass && !wr_valid && wr_ready) |=> $stable(count));

  assert_inactive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !bypass) |-> !active);
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .dbg_halt(dbg_halt), .bypass(bypass_w), .clr_req(clr_req),
  .cmp_eff(cmp_eff), .count(count), .match_pulse(match_pulse), .active(active)
);

// File: tb/match_timer_test.sv
`timescale 1ns/1ps
module match_timer_test;
  localparam logic [31:0] RUN = 32'h01, CLR = 32'h02, BYP = 32'h04;
  localparam logic [31:0] EVT = 32'h08, RISE = 32'h10, FILT = 32'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        dbg_halt = 1'b0;
  logic        evt_pin = 1'b0;
  logic [23:0] count;
  logic        match_pulse;
  logic        active;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  match_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .dbg_halt(dbg_halt), .evt_pin(evt_pin),
    .count(count), .match_pulse(match_pulse), .active(active)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic wr(logic [1:0] a, logic [31:0] d);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;  // R1
    chk("R1 count", count, 0);
    chk("R1 match", match_pulse, 0);
    chk("R1 active", active, 0);
    chk("R1 ready", wr_ready, 1);
  endtask

  task automatic t_prescale;  // R2, R10
    wr(2'd1, 32'd2);
    wr(2'd2, 32'd100);
    wr(2'd0, RUN);
    chk("R10 active when enabled", active, 1);
    chk("R2 no step yet", count, 0);
    idle(2); chk("R2 before P+1", count, 0);
    idle(1); chk("R2 first step", count, 1);
    idle(3); chk("R2 second step", count, 2);
  endtask

  task automatic t_match;  // R3
    logic [23:0] ec [5] = '{1, 2, 3, 0, 1};
    logic        em [5] = '{0, 0, 1, 0, 0};
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd3);
    chk("R5 restart on compare write", count, 0);
    for (int i = 0; i < 5; i++) begin
      idle(1);
      chk("R3 count", count, ec[i]);
      chk("R3 match", match_pulse, em[i]);
    end
  endtask

  task automatic t_clamp;  // R4
    logic [23:0] ec [4] = '{1, 2, 0, 1};
    logic        em [4] = '{0, 1, 0, 0};
    for (int v = 0; v < 2; v++) begin
      wr(2'd2, 32'(v));
      for (int i = 0; i < 4; i++) begin
        idle(1);
        chk("R4 clamped count", count, ec[i]);
        chk("R4 clamped match", match_pulse, em[i]);
      end
    end
  endtask

  task automatic t_restart;  // R5
    wr(2'd2, 32'd100);
    idle(5); chk("R5 running", count, 5);
    wr(2'd0, 32'd0);
    chk("R5 last step", count, 6);
    idle(4); chk("R5 disabled holds", count, 6);
    wr(2'd2, 32'd50);
    chk("R5 restart while disabled", count, 0);
    idle(3); chk("R5 stays zero", count, 0);
  endtask

  task automatic t_soft;  // R6
    wr(2'd0, RUN);
    idle(4); chk("R6 pre-clear count", count, 4);
    wr(2'd0, RUN | CLR);
    chk("R6 count cleared", count, 0);
    chk("R6 ready low 1", wr_ready, 0);
    chk("R6 enable forced off", active, 0);
    idle(1); chk("R6 ready low 2", wr_ready, 0);
    idle(1); chk("R6 ready low 3", wr_ready, 0);
    idle(1); chk("R6 ready back", wr_ready, 1);
    idle(3); chk("R6 no counting after clear", count, 0);
  endtask

  task automatic t_debug;  // R7, R10
    wr(2'd2, 32'd1000);
    wr(2'd0, RUN);
    idle(3); chk("R7 running", count, 3);
    dbg_halt = 1'b1;
    idle(1); chk("R7 frozen", count, 3);
    chk("R10 inactive while frozen", active, 0);
    idle(3); chk("R7 still frozen", count, 3);
    wr(2'd0, RUN | BYP);
    chk("R7 bypass write edge frozen", count, 3);
    chk("R10 active with bypass", active, 1);
    idle(3); chk("R7 bypass counts", count, 6);
    dbg_halt = 1'b0;
  endtask

  task automatic t_event;  // R8
    wr(2'd0, EVT | RISE);
    wr(2'd2, 32'd1000);
    wr(2'd0, RUN | EVT | RISE);
    idle(3); chk("R8 prescaler ignored", count, 0);
    evt_pin = 1'b1;
    idle(3); chk("R8 rise not yet", count, 0);
    idle(1); chk("R8 rise counted", count, 1);
    evt_pin = 1'b0;
    idle(8); chk("R8 fall ignored", count, 1);
    wr(2'd0, RUN | EVT);
    evt_pin = 1'b1;
    idle(8); chk("R8 rise ignored in fall mode", count, 1);
    evt_pin = 1'b0;
    idle(3); chk("R8 fall not yet", count, 1);
    idle(1); chk("R8 fall counted", count, 2);
  endtask

  task automatic t_filter;  // R9
    wr(2'd0, RUN | EVT | RISE | FILT);
    evt_pin = 1'b1;
    idle(2);
    evt_pin = 1'b0;
    idle(12); chk("R9 glitch rejected", count, 2);
    evt_pin = 1'b1;
    idle(7); chk("R9 not yet", count, 2);
    idle(1); chk("R9 filtered edge counted", count, 3);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_prescale();
    t_match();
    t_clamp();
    t_restart();
    t_soft();
    t_debug();
    t_event();
    t_filter();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule